// File: doc/BRIEF.md
# Bus Request/Grant Handover Controller

This block decides when a processor lets go of its external address and data buses so that an outside master can use them. It watches a bus-request input and the processor's external-access state. From these it drives a bus-grant output, an output-enable for the address, data, memory-select and read/write strobe drivers, a halt line to the core, and a permit line that tells the core whether it may start a new external access.

The request input may arrive from another clock domain, so it passes through a synchroniser chain before the block uses it. A grant never cuts an access that is already on the bus. It waits for that access to finish. It may still slip in between two accesses made by the same instruction. In the normal mode the core halts for as long as the grant is held. In the continue-running mode the core halts only while it is granted away and actually needs the bus.

The only reset is the block's own `rst_n`. The block has no processor-reset or boot input, so holding the core in reset or running a boot load does not stop request and grant handling.

Top module: `bus_handover_ctrl`

## Requirements
- R1: After `rst_n` is released and with `bus_req` low, the outputs are `bus_grant`=0, `drv_en`=1, `core_halt`=0 and `acc_allow`=1.
- R2: All signals are active-high. Suppose `bus_req` is first driven high in cycle r and no external access is in progress. Then `bus_grant` rises at the third rising edge after that, so it is seen in cycle r+3. This is one cycle after the synchronised request is seen in cycle r+2.
- R3: Whenever `bus_grant` is 1, `drv_en` is 0. Whenever `bus_grant` is 0, `drv_en` is 1.
- R4: Suppose an access occupies cycles 0..L-1, with 1 <= L <= 8 (up to seven wait states). `acc_busy` is high in every one of those cycles and `acc_done` is high only in the last. If a request is made in cycle r, `bus_grant` is first seen in cycle max(r+2, L-1)+1. The grant never rises while an access is still incomplete.
- R5: `acc_allow` is 0 from the cycle the synchronised request is high until the grant has been released. A second access of the same instruction therefore cannot start, and the grant is inserted between the two accesses.
- R6: With `go_mode`=0, `core_halt` equals `bus_grant`.
- R7: With `go_mode`=1 and `bus_grant`=1, `core_halt` is 1 only while `acc_pending` is 1. It follows `acc_pending` in the same cycle.
- R8: Suppose `bus_req` is driven low in cycle d while the grant is held. Then `bus_grant` is 0 from cycle d+3, with `drv_en` back to 1 and `core_halt` back to 0. `acc_allow` returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| bus_req | input | 1 | Request from the outside master, may be asynchronous |
| acc_busy | input | 1 | An external access is on the bus this cycle |
| acc_done | input | 1 | This cycle is the last cycle of the current access |
| acc_pending | input | 1 | The core needs an external access next |
| go_mode | input | 1 | 1 = keep executing while granted until the bus is needed |
| bus_grant | output | 1 | Bus handed to the outside master |
| drv_en | output | 1 | Output-enable for bus, select and strobe drivers |
| core_halt | output | 1 | Stall request to the core |
| acc_allow | output | 1 | Core may begin a new external access |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser, accesses of up to eight cycles, and the continue-running mode enabled. With these values, every access length from one to eight cycles is swept against every request arrival from cycle 0 to cycle 8. This covers the case where the request lands before the access, the case where it lands exactly on the completing cycle, and the case where it lands after the access. Each case runs through grant and release. The expected grant and release cycles are computed as max(r+2, L-1)+1 and d+3. A separate pass drives the continue-running mode with the pending-access line toggled while the grant is held.

// File: rtl/bh_pkg.sv
package bh_pkg;
   typedef enum logic {
      BH_OWNER  = 1'b0,
      BH_HANDED = 1'b1
   } bh_state_e;

   // true when an access does not block the handover this cycle
   function automatic logic bh_bus_free(input logic busy, input logic done);
      return !busy || done;
   endfunction
endpackage

// File: rtl/bh_req_sync.sv
module bh_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/bh_grant_fsm.sv
module bh_grant_fsm
   import bh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic acc_busy,
   input  logic acc_done,
   output logic bus_grant,
   output logic drv_en
);
   bh_state_e state, state_nxt;

   always_comb begin
      state_nxt = state;
      unique case (state)
         BH_OWNER:  if (req_s && bh_bus_free(acc_busy, acc_done)) state_nxt = BH_HANDED;
         BH_HANDED: if (!req_s) state_nxt = BH_OWNER;
         default:   state_nxt = BH_OWNER;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= BH_OWNER;
         bus_grant <= 1'b0;
         drv_en    <= 1'b1;
      end else begin
         state     <= state_nxt;
         bus_grant <= (state_nxt == BH_HANDED);
         drv_en    <= (state_nxt == BH_OWNER);
      end
   end
endmodule

// File: rtl/bh_halt_ctrl.sv
module bh_halt_ctrl #(
   parameter bit GO_MODE_EN = 1'b1
) (
   input  logic bus_grant,
   input  logic req_s,
   input  logic go_mode,
   input  logic acc_pending,
   output logic core_halt,
   output logic acc_allow
);
   // no new access once the request is seen or the bus is away
   assign acc_allow = !bus_grant && !req_s;

   generate
      if (GO_MODE_EN) begin : g_go
         assign core_halt = bus_grant && (!go_mode || acc_pending);
      end else begin : g_plain
         logic unused_go;
         assign unused_go = go_mode ^ acc_pending;
         assign core_halt = bus_grant;
      end
   endgenerate
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl #(
   parameter int SYNC_STAGES       = 2,
   parameter int MAX_ACCESS_CYCLES = 8,
   parameter bit GO_MODE_EN        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req,
   input  logic acc_busy,
   input  logic acc_done,
   input  logic acc_pending,
   input  logic go_mode,
   output logic bus_grant,
   output logic drv_en,
   output logic core_halt,
   output logic acc_allow
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MAX_ACCESS_CYCLES < 1) begin : g_bad_acc
         $error("MAX_ACCESS_CYCLES must be at least 1");
      end
   endgenerate

   logic req_s;

   bh_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (bus_req),
      .q_out (req_s)
   );

   bh_grant_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_s     (req_s),
      .acc_busy  (acc_busy),
      .acc_done  (acc_done),
      .bus_grant (bus_grant),
      .drv_en    (drv_en)
   );

   bh_halt_ctrl #(.GO_MODE_EN(GO_MODE_EN)) u_halt (
      .bus_grant   (bus_grant),
      .req_s       (req_s),
      .go_mode     (go_mode),
      .acc_pending (acc_pending),
      .core_halt   (core_halt),
      .acc_allow   (acc_allow)
   );
endmodule

// File: rtl/bh_checker.sv
module bh_checker #(
   parameter int MAX_ACCESS_CYCLES = 8
) (
   input logic clk,
   input logic rst_n,
   input logic req_s,
   input logic acc_busy,
   input logic acc_done,
   input logic acc_pending,
   input logic go_mode,
   input logic bus_grant,
   input logic drv_en,
   input logic core_halt,
   input logic acc_allow
);
   localparam int CNT_W = $clog2(MAX_ACCESS_CYCLES + 2);
   logic [CNT_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wait_cnt <= '0;
      else if (req_s && !bus_grant) begin
         if (wait_cnt != {CNT_W{1'b1}}) wait_cnt <= wait_cnt + 1'b1;
      end else                     wait_cnt <= '0;
   end

   // R3
   a_r3_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> !drv_en);
   // R2
   a_r2_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_grant && req_s && (!acc_busy || acc_done)) |=> bus_grant);
   // R4
   a_r4_no_break: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_busy && !acc_done) |=> !$rose(bus_grant));
   // R4
   a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= CNT_W'(MAX_ACCESS_CYCLES));
   // R5
   a_r5_no_new_access: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant || req_s) |-> !acc_allow);
   // R7
   a_r7_go_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (go_mode && !acc_pending) |-> !core_halt);
   // R6
   a_r6_halt_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_mode) |-> (core_halt == bus_grant));
   // R8
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && !req_s) |=> (!bus_grant && drv_en));
endmodule

bind bus_handover_ctrl bh_checker #(.MAX_ACCESS_CYCLES(MAX_ACCESS_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_s       (req_s),
   .acc_busy    (acc_busy),
   .acc_done    (acc_done),
   .acc_pending (acc_pending),
   .go_mode     (go_mode),
   .bus_grant   (bus_grant),
   .drv_en      (drv_en),
   .core_halt   (core_halt),
   .acc_allow   (acc_allow)
);

// File: tb/sim_bus_handover_ctrl.sv
`timescale 1ns/1ps
module sim_bus_handover_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_req = 1'b0, acc_busy = 1'b0, acc_done = 1'b0;
   logic acc_pending = 1'b0, go_mode = 1'b0;
   logic bus_grant, drv_en, core_halt, acc_allow;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   bus_handover_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .acc_busy(acc_busy),
      .acc_done(acc_done), .acc_pending(acc_pending), .go_mode(go_mode),
      .bus_grant(bus_grant), .drv_en(drv_en), .core_halt(core_halt),
      .acc_allow(acc_allow)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_req = 1'b0; acc_busy = 1'b0; acc_done = 1'b0; acc_pending = 1'b0;
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      #1;
      chk("R1 grant", bus_grant, 1'b0);
      chk("R1 drv_en", drv_en, 1'b1);
      chk("R1 halt", core_halt, 1'b0);
      chk("R1 allow", acc_allow, 1'b1);

      // sweep access length against request arrival, normal mode
      for (int len = 1; len <= 8; len++) begin
         for (int r = 0; r <= 8; r++) begin
            int g;
            g = ((r + 2) > (len - 1) ? (r + 2) : (len - 1)) + 1;
            for (int c = 0; c <= g + 8; c++) begin
               logic eg, ea;
               @(negedge clk);
               acc_busy = (c < len);
               acc_done = (c == len - 1);
               bus_req  = (c >= r) && (c < g + 3);
               #1;
               eg = (c >= g) && (c < g + 6);
               ea = (c < r + 2) || (c >= g + 6);
               if (c >= g + 3) chk("R8 grant release", bus_grant, eg);
               else if (len - 1 > r + 2) chk("R4 grant after access", bus_grant, eg);
               else chk("R2 grant timing", bus_grant, eg);
               chk("R3 drv_en", drv_en, !eg);
               chk("R5 allow", acc_allow, ea);
               chk("R6 halt", core_halt, eg);
            end
            idle(4);
         end
      end

      // continue-running mode
      go_mode = 1'b1;
      for (int c = 0; c <= 12; c++) begin
         logic eg;
         @(negedge clk);
         bus_req = (c < 9);
         acc_pending = (c == 5) || (c == 6);
         #1;
         eg = (c >= 3) && (c < 12);
         chk("R7 grant", bus_grant, eg);
         chk("R7 halt", core_halt, eg && acc_pending);
         chk("R3 drv_en go", drv_en, !eg);
      end
      idle(4);
      #1;
      chk("R8 halt after", core_halt, 1'b0);
      chk("R8 allow after", acc_allow, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule